// File: doc/BRIEF.md
# Shared-Line Serial ADC Reader

This block is the master side of the link to a delta-sigma converter that uses a single pin both as its "result ready" flag and as its serial data output. While the converter is busy, the pin sits high. When a conversion completes, the converter pulls the pin low and holds it there until clock pulses arrive. The reader passes the pin through a two-flop synchronizer and watches it. Once it sees the pin low while its own serial clock is low, it produces 25 clock pulses. The first 24 pulses shift in the result MSB first. The converter drives each bit after a rising edge, and the reader samples it at the end of the high phase. The 25th pulse carries no data; its only job is to return the pin to high.

After the 25th pulse, the reader presents the 24-bit word on a parallel output together with a one-cycle valid strobe. The word then stays unchanged until the next result arrives. The reader re-arms only after it has seen the pin high again. The high and low phases of the serial clock each last `HALF_DIV` system clocks. With a 100 MHz system clock, the default of 1000 gives roughly 10 µs per phase, so a whole 25-pulse read fits easily inside one conversion period.

The state machine has five states:
- `ST_WAIT_RDY`: waits for the synchronized pin to read low while the serial clock is low. This is the "start" transition, and it leads to `ST_SCLK_HI`.
- `ST_SCLK_HI`: the serial clock is high. When the phase timer expires, the "sample" transition captures a data bit (pulses 1 to 24 only) and leads to `ST_SCLK_LO`.
- `ST_SCLK_LO`: the serial clock is low. When the phase timer expires, the "next pulse" transition returns to `ST_SCLK_HI`, or, once 25 pulses are done, the "finish" transition leads to `ST_PRESENT`.
- `ST_PRESENT`: raises the valid strobe for one cycle. It then moves unconditionally to `ST_REARM`.
- `ST_REARM`: waits for the pin to read high. This is the "re-arm" transition, and it leads back to `ST_WAIT_RDY`.

Top module: `adc_line_reader`

## Requirements
- R1: While reset is active, and in the first cycle after it is released, `sclk_o` is 0, `word_o` is all zeros and `word_valid_o` is 0.
- R2: A read begins only when the synchronized `rdy_data_i` reads 0 while `sclk_o` is 0. No serial clock pulse occurs while the line stays high.
- R3: Each read produces exactly DATA_W+1 (25) rising edges on `sclk_o` before its valid strobe.
- R4: During a read, every high phase of `sclk_o` lasts exactly HALF_DIV system clocks. Every low phase between pulses, including the one after the last pulse, also lasts HALF_DIV system clocks.
- R5: `word_o` holds the bits sampled during the high phases of pulses 1 to DATA_W. The bit from pulse 1 lands in bit DATA_W-1 (MSB first), and the bit from pulse DATA_W lands in bit 0. The line level during pulse DATA_W+1 is not stored.
- R6: `word_valid_o` is high for exactly one system clock. It rises HALF_DIV system clocks after the last falling edge of `sclk_o`. `word_o` changes only in the cycle where `word_valid_o` is high.
- R7: After a read completes, if the line is still low, no new pulse is produced until the line has first been seen high.
- R8: Between reads, `sclk_o` stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rdy_data_i | input | 1 | Combined ready / serial data line from the converter, idle high |
| sclk_o | output | 1 | Serial clock to the converter, idle low |
| word_o | output | DATA_W | Last complete conversion result |
| word_valid_o | output | 1 | One-cycle strobe marking a new result on `word_o` |

## Verification
The bench builds the reader with `HALF_DIV` = 4, the smallest phase length that still leaves the synchronizer's two-cycle delay inside the high phase. At that setting a full read takes about 200 cycles, so many reads fit in one run: all-zero, all-one, alternating and single-MSB/LSB words. The short phase also makes any shortfall in the sampling margin show up as a wrong bit. One read leaves the line low after the 25th pulse, which exercises the re-arm wait. The long idle gaps between reads confirm that a high line never starts a clock.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_WAIT_RDY = 3'd0,
        ST_SCLK_HI  = 3'd1,
        ST_SCLK_LO  = 3'd2,
        ST_PRESENT  = 3'd3,
        ST_REARM    = 3'd4
    } rd_state_t;

endpackage

// File: rtl/adc_line_sync.sv
// Multi-stage synchronizer for the asynchronous ready/data line.
// Resets to 1 so that the idle-high line is never mistaken for "ready".
module adc_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b1;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/adc_half_timer.sv
// Counts system clocks within one serial-clock phase. Pulses tick on the
// last cycle of the phase and wraps, so back-to-back phases are equal.
module adc_half_timer #(
    parameter int HALF_DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = en && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!en)    cnt_q <= '0;
        else if (tick)   cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/adc_shift_in.sv
// MSB-first shift register: each new bit enters at bit 0.
module adc_shift_in #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (shift) q <= {q[W-2:0], din};
    end
endmodule

// File: rtl/adc_line_reader.sv
module adc_line_reader #(
    parameter int DATA_W   = 24,
    parameter int HALF_DIV = 1000,
    parameter int SYNC_N   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rdy_data_i,
    output logic              sclk_o,
    output logic [DATA_W-1:0] word_o,
    output logic              word_valid_o
);
    import adc_rd_pkg::*;

    localparam int PULSES = DATA_W + 1;
    localparam int BIT_W  = $clog2(PULSES + 1);
    localparam logic [BIT_W-1:0] PULSE_LAST = BIT_W'(PULSES);
    localparam logic [BIT_W-1:0] DATA_LAST  = BIT_W'(DATA_W);

    rd_state_t         state_q, state_d;
    logic              line_s;
    logic              phase_tick;
    logic              phase_en;
    logic              shift_en;
    logic [BIT_W-1:0]  bit_cnt_q;
    logic [DATA_W-1:0] shift_q;
    logic              sclk_q;
    logic              valid_q;
    logic [DATA_W-1:0] word_q;

    adc_line_sync #(.STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rdy_data_i),
        .q     (line_s)
    );

    assign phase_en = (state_q == ST_SCLK_HI) || (state_q == ST_SCLK_LO);

    adc_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (phase_en),
        .tick  (phase_tick)
    );

    // Sample at the end of the high phase, for data pulses only.
    assign shift_en = (state_q == ST_SCLK_HI) && phase_tick && (bit_cnt_q < DATA_LAST);

    adc_shift_in #(.W(DATA_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (shift_en),
        .din   (line_s),
        .q     (shift_q)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_RDY: if (!line_s && !sclk_q)   state_d = ST_SCLK_HI;   // start
            ST_SCLK_HI:  if (phase_tick)           state_d = ST_SCLK_LO;   // sample
            ST_SCLK_LO:  if (phase_tick)
                             state_d = (bit_cnt_q == PULSE_LAST) ? ST_PRESENT  // finish
                                                                 : ST_SCLK_HI; // next pulse
            ST_PRESENT:                            state_d = ST_REARM;
            ST_REARM:    if (line_s)               state_d = ST_WAIT_RDY;  // re-arm
            default:                               state_d = ST_WAIT_RDY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT_RDY;
        else        state_q <= state_d;
    end

    // Pulse counter: incremented at the end of each high phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    bit_cnt_q <= '0;
        else if (state_q == ST_WAIT_RDY)               bit_cnt_q <= '0;
        else if ((state_q == ST_SCLK_HI) && phase_tick) bit_cnt_q <= bit_cnt_q + 1'b1;
    end

    // Registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            valid_q <= 1'b0;
            word_q  <= '0;
        end else begin
            sclk_q  <= (state_d == ST_SCLK_HI);
            valid_q <= (state_d == ST_PRESENT);
            if ((state_d == ST_PRESENT) && (state_q != ST_PRESENT))
                word_q <= shift_q;
        end
    end

    assign sclk_o       = sclk_q;
    assign word_valid_o = valid_q;
    assign word_o       = word_q;
endmodule

// File: rtl/adc_line_reader_chk.sv
module adc_line_reader_chk #(
    parameter int DATA_W   = 24,
    parameter int HALF_DIV = 1000
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sclk,
    input logic                  valid,
    input logic [DATA_W-1:0]     word,
    input adc_rd_pkg::rd_state_t state
);
    import adc_rd_pkg::*;

    logic        sclk_d;
    logic [31:0] hi_run;
    logic [31:0] rise_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d   <= 1'b0;
            hi_run   <= '0;
            rise_cnt <= '0;
        end else begin
            sclk_d <= sclk;
            hi_run <= sclk ? hi_run + 1 : 32'd0;
            if (valid)               rise_cnt <= '0;
            else if (sclk && !sclk_d) rise_cnt <= rise_cnt + 1;
        end
    end

    // R4
    hi_phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk && sclk_d) |-> (hi_run == 32'(HALF_DIV)));

    // R3
    pulse_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (rise_cnt == 32'(DATA_W + 1)));

    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R6
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (valid || $stable(word)));

    // R8
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_RDY) |-> !sclk);

    // R7
    rearm_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REARM) |-> !sclk);
endmodule

bind adc_line_reader adc_line_reader_chk #(
    .DATA_W   (DATA_W),
    .HALF_DIV (HALF_DIV)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .sclk  (sclk_o),
    .valid (word_valid_o),
    .word  (word_o),
    .state (state_q)
);

// File: tb/sim_adc_line_reader.sv
`timescale 1ns/1ps
module sim_adc_line_reader;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 24;
    localparam int HD         = 4;
    localparam int PULSES     = DW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line = 1'b1;
    logic          sclk;
    logic [DW-1:0] word;
    logic          valid;

    adc_line_reader #(.DATA_W(DW), .HALF_DIV(HD)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .rdy_data_i   (line),
        .sclk_o       (sclk),
        .word_o       (word),
        .word_valid_o (valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- converter model ----------------
    logic [DW-1:0] adc_word;
    int            edge_cnt = 0;
    bit            hold_low = 1'b0;

    always @(posedge sclk) begin
        edge_cnt++;
        if (edge_cnt <= DW) line <= adc_word[DW - edge_cnt];
        else                line <= hold_low ? 1'b0 : 1'b1;
    end

    // ---------------- reference model ----------------
    logic [DW-1:0] exp_q[$];
    bit            xfer_active = 1'b0;
    logic [DW-1:0] last_word = '0;
    bit            prev_sclk = 1'b0;
    bit            prev_valid = 1'b0;
    int            hi_len = 0;
    int            lo_len = 0;
    int            rises = 0;
    int            valid_seen = 0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            // R8 / R2 / R7: no clock outside an announced read
            if (!xfer_active) check(sclk == 1'b0, "R8/R2/R7 sclk outside read", sclk, 0);
            if (sclk && !prev_sclk) begin
                rises++;
                if (rises > 1) check(lo_len == HD, "R4 low phase", lo_len, HD);
                hi_len = 0;
            end
            if (!sclk && prev_sclk) begin
                check(hi_len == HD, "R4 high phase", hi_len, HD);
                lo_len = 0;
            end
            if (sclk) hi_len++; else lo_len++;

            if (valid) begin
                check(!prev_valid, "R6 valid one cycle", prev_valid, 0);
                check(rises == PULSES, "R3 pulse count", rises, PULSES);
                check(lo_len == HD + 1, "R6 valid timing", lo_len, HD + 1);
                if (exp_q.size() > 0) begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    check(word == e, "R5 word value", word, e);
                end else begin
                    check(1'b0, "R6 unexpected valid", 1, 0);
                end
                last_word = word;
                rises = 0;
                valid_seen++;
                xfer_active = 1'b0;
            end else begin
                check(word == last_word, "R6 word stable", word, last_word);
            end
            prev_sclk  = sclk;
            prev_valid = valid;
        end
    end

    task automatic convert(input logic [DW-1:0] w, input bit stay_low);
        int start_seen;
        start_seen = valid_seen;
        @(negedge clk);
        adc_word    = w;
        edge_cnt    = 0;
        hold_low    = stay_low;
        exp_q.push_back(w);
        xfer_active = 1'b1;
        line        = 1'b0;
        for (int i = 0; i < 2000 && valid_seen == start_seen; i++) @(negedge clk);
        check(valid_seen == start_seen + 1, "R3 read completed", valid_seen, start_seen + 1);
        if (stay_low) begin
            // R7: line still low, no pulses allowed (monitor checks sclk each cycle)
            repeat (40) @(negedge clk);
            check(sclk == 1'b0, "R7 held low no restart", sclk, 0);
            hold_low = 1'b0;
            line     = 1'b1;
        end
        repeat (30) @(negedge clk); // R2: idle gap with line high
        check(sclk == 1'b0, "R2 idle line high", sclk, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(sclk == 1'b0,  "R1 sclk in reset", sclk, 0);
        check(word == '0,    "R1 word in reset", word, 0);
        check(valid == 1'b0, "R1 valid in reset", valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sclk == 1'b0 && valid == 1'b0 && word == '0, "R1 after release", {sclk, valid}, 0);
        repeat (20) @(negedge clk);

        convert(24'hA5C3F0, 1'b0);
        convert(24'h000000, 1'b0);
        convert(24'hFFFFFF, 1'b0);
        convert(24'h800001, 1'b0);   // R5 MSB and LSB positions
        convert(24'h123456, 1'b1);   // R7 line stays low after last pulse
        convert(24'h555555, 1'b0);
        convert(24'hFEDCBA, 1'b0);

        check(exp_q.size() == 0, "R6 all results delivered", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule